// File: doc/BRIEF.md
# Two-Port Processor Mailbox

The block links two processors that share one clock. Each processor owns a small register port with a write strobe, a read strobe, a byte offset and a 32-bit data word. A word that one side stores at its send-data offset is queued and later taken from the receive-data offset of the other side. The two directions use independent 16-entry queues, so traffic flowing one way never blocks or reorders traffic flowing the other way.

Both ports present the same register set, and each side sees it from its own point of view. The registers are: status flags for its two queues, sticky error flags that clear when read, two 4-bit fill thresholds, an interrupt status register cleared by writing ones, an interrupt enable mask and a read-only pending view. Each side has one interrupt line. It is raised when a threshold condition has risen since the last clear and that condition is enabled.

Register reads are combinational. The read data is valid in the cycle the read strobe is high. Side effects of a read (dequeue, error clear) take place at the clock edge that ends that cycle.

Top module: `dual_mailbox`

## Requirements
- R1: Offsets are decoded on the full byte offset: 0x00 send data, 0x08 receive data, 0x10 status, 0x14 error, 0x18 send threshold, 0x1C receive threshold, 0x20 interrupt status, 0x24 interrupt enable, 0x28 pending. Any other offset reads as zero, and a write to it changes nothing.
- R2: Words written at 0x00 on one side are returned in the same order from 0x08 on the other side. Each direction is a separate queue.
- R3: A write to 0x00 while the outgoing queue is full is dropped and sets error bit 1.
- R4: A read of 0x08 while the incoming queue is empty returns zero, removes nothing and sets error bit 0.
- R5: Status is read-only. Bit 0 means the incoming queue is empty. Bit 1 means the outgoing queue is full. Bit 2 means the outgoing fill is below the send threshold. Bit 3 means the incoming fill is above the receive threshold. Status reads 0x1 after reset.
- R6: The error register reads 0x0 after reset. It is read-only, and a read of it returns its flags and then clears them.
- R7: The thresholds are 4 bits wide, and the enable register covers bits 1:0; both read back what was written. A read of 0x00 returns zero. A write to the pending register has no effect.
- R8: Interrupt status bit 0 sets when the status bit 2 condition rises, and bit 1 sets when the status bit 3 condition rises. A bit stays set until a 1 is written to it. A bit does not set again while its condition stays true.
- R9: Pending reads as interrupt status AND enable. A side's interrupt output is high exactly when its pending value is non-zero.
- R10: Each queue holds 16 words. The 16th write sets the full flag, and all 16 words are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| aWrEn | input | 1 | Side A write strobe |
| aRdEn | input | 1 | Side A read strobe |
| aAddr | input | 6 | Side A byte offset |
| aWrData | input | 32 | Side A write data |
| aRdData | output | 32 | Side A read data, valid while aRdEn is high |
| aIrq | output | 1 | Side A interrupt |
| bWrEn | input | 1 | Side B write strobe |
| bRdEn | input | 1 | Side B read strobe |
| bAddr | input | 6 | Side B byte offset |
| bWrData | input | 32 | Side B write data |
| bRdData | output | 32 | Side B read data, valid while bRdEn is high |
| bIrq | output | 1 | Side B interrupt |

## Verification
The hardest case to reach is a threshold interrupt that has to appear on an edge of its condition. Earlier traffic leaves stale status bits behind, so the bench first reprograms the thresholds and clears the status with a write of ones. Only then does the other side push words across the receive threshold, one at a time. The bench then checks that status, pending and the interrupt line rise together. It also checks that a clear while the condition stays true does not set the bit again. Filling a queue to capacity takes sixteen writes followed by one more, which gives the overflow path and the exact-capacity boundary in the same run.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int SIDES = 2;

  typedef struct packed {
    logic push;   // enqueue wrData into this side's outgoing queue
    logic pop;    // dequeue head of this side's incoming queue
  } mbox_strobe_t;

  typedef enum logic [3:0] {
    IDX_SEND   = 4'd0,
    IDX_RECV   = 4'd2,
    IDX_STATUS = 4'd4,
    IDX_ERROR  = 4'd5,
    IDX_STHR   = 4'd6,
    IDX_RTHR   = 4'd7,
    IDX_ISTAT  = 4'd8,
    IDX_IEN    = 4'd9,
    IDX_IPEND  = 4'd10
  } mbox_idx_e;
endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        push,
  input  logic                        pop,
  input  logic [DATA_W-1:0]           wrWord,
  output logic [DATA_W-1:0]           headWord,
  output logic [$clog2(DEPTH+1)-1:0]  fill
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign headWord = mem[rdPtr];

  // R3: control must never push into a full queue
  a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    !(push && fill == CNT_W'(DEPTH)));
  // R4: control must never pop an empty queue
  a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    !(pop && fill == '0));
  // R10: fill stays within capacity
  a_r10_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNT_W'(DEPTH));
endmodule

// File: rtl/mbox_side_ctrl.sv
module mbox_side_ctrl
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int THR_W  = 4,
  parameter int ADDR_W = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [$clog2(DEPTH+1)-1:0]  outFill,
  input  logic [$clog2(DEPTH+1)-1:0]  inFill,
  input  logic [DATA_W-1:0]           inHead,
  output logic [DATA_W-1:0]           rdData,
  output logic                        irq,
  output mbox_strobe_t                strobe
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [THR_W-1:0] sendThr, recvThr;
  logic [1:0]       irqEn, irqStat, errFlags;
  logic             prevSend, prevRecv;
  logic             hit;
  logic [3:0]       idx;
  logic             inEmpty, outFull, sendCond, recvCond;
  logic             wrSend, rdRecv, rdErr;
  logic [3:0]       statusWord;
  logic [1:0]       pendWord;

  assign hit = (addr[1:0] == 2'b00);
  assign idx = hit ? addr[5:2] : 4'hF;

  assign inEmpty  = (inFill == '0);
  assign outFull  = (outFill == CNT_W'(DEPTH));
  assign sendCond = CMP_W'(outFill) < CMP_W'(sendThr);
  assign recvCond = CMP_W'(inFill)  > CMP_W'(recvThr);

  assign statusWord = {recvCond, sendCond, outFull, inEmpty};
  assign pendWord   = irqStat & irqEn;
  assign irq        = |pendWord;

  assign wrSend = wrEn && idx == IDX_SEND;
  assign rdRecv = rdEn && idx == IDX_RECV;
  assign rdErr  = rdEn && idx == IDX_ERROR;

  assign strobe.push = wrSend && !outFull;
  assign strobe.pop  = rdRecv && !inEmpty;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (idx)
        IDX_RECV:   rdData = inEmpty ? '0 : inHead;
        IDX_STATUS: rdData = DATA_W'(statusWord);
        IDX_ERROR:  rdData = DATA_W'(errFlags);
        IDX_STHR:   rdData = DATA_W'(sendThr);
        IDX_RTHR:   rdData = DATA_W'(recvThr);
        IDX_ISTAT:  rdData = DATA_W'(irqStat);
        IDX_IEN:    rdData = DATA_W'(irqEn);
        IDX_IPEND:  rdData = DATA_W'(pendWord);
        default:    rdData = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sendThr  <= '0;
      recvThr  <= '0;
      irqEn    <= '0;
      irqStat  <= '0;
      errFlags <= '0;
      prevSend <= 1'b0;
      prevRecv <= 1'b0;
    end else begin
      prevSend <= sendCond;
      prevRecv <= recvCond;
      if (wrEn && idx == IDX_STHR) sendThr <= wrData[THR_W-1:0];
      if (wrEn && idx == IDX_RTHR) recvThr <= wrData[THR_W-1:0];
      if (wrEn && idx == IDX_IEN)  irqEn   <= wrData[1:0];
      irqStat <= (irqStat & ~((wrEn && idx == IDX_ISTAT) ? wrData[1:0] : 2'b00))
               | {recvCond && !prevRecv, sendCond && !prevSend};
      errFlags <= (rdErr ? 2'b00 : errFlags)
                | {wrSend && outFull, rdRecv && inEmpty};
    end
  end

  // R3: overflowing write flags the error
  a_r3_full_flag: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == IDX_SEND && outFill == CNT_W'(DEPTH)) |=> errFlags[1]);
  // R4: empty read flags the error
  a_r4_empty_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && idx == IDX_RECV && inFill == '0) |=> errFlags[0]);
  // R6: error register is cleared by its read
  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |=> errFlags == 2'b00);
  // R8: a rising send condition latches interrupt status
  a_r8_send_edge: assert property (@(posedge clk) disable iff (!rstN)
    (sendCond && !prevSend) |=> irqStat[0]);
  // R8: a rising receive condition latches interrupt status
  a_r8_recv_edge: assert property (@(posedge clk) disable iff (!rstN)
    (recvCond && !prevRecv) |=> irqStat[1]);
  // R9: interrupt line low whenever nothing is enabled
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn == 2'b00) |-> !irq);
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int THR_W  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aWrEn,
  input  logic              aRdEn,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWrData,
  output logic [DATA_W-1:0] aRdData,
  output logic              aIrq,
  input  logic              bWrEn,
  input  logic              bRdEn,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWrData,
  output logic [DATA_W-1:0] bRdData,
  output logic              bIrq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic              sWrEn   [SIDES];
  logic              sRdEn   [SIDES];
  logic [ADDR_W-1:0] sAddr   [SIDES];
  logic [DATA_W-1:0] sWrData [SIDES];
  logic [DATA_W-1:0] sRdData [SIDES];
  logic              sIrq    [SIDES];
  mbox_strobe_t      sStrobe [SIDES];
  logic [DATA_W-1:0] qHead   [SIDES];
  logic [CNT_W-1:0]  qFill   [SIDES];

  assign sWrEn[0] = aWrEn;  assign sWrEn[1] = bWrEn;
  assign sRdEn[0] = aRdEn;  assign sRdEn[1] = bRdEn;
  assign sAddr[0] = aAddr;  assign sAddr[1] = bAddr;
  assign sWrData[0] = aWrData;  assign sWrData[1] = bWrData;
  assign aRdData = sRdData[0];  assign bRdData = sRdData[1];
  assign aIrq = sIrq[0];        assign bIrq = sIrq[1];

  // queue s carries words written by side s to side 1-s
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    mbox_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
      .clk      (clk),
      .rstN     (rstN),
      .push     (sStrobe[s].push),
      .pop      (sStrobe[SIDES-1-s].pop),
      .wrWord   (sWrData[s]),
      .headWord (qHead[s]),
      .fill     (qFill[s])
    );

    mbox_side_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W),
                     .ADDR_W(ADDR_W)) u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .wrEn    (sWrEn[s]),
      .rdEn    (sRdEn[s]),
      .addr    (sAddr[s]),
      .wrData  (sWrData[s]),
      .outFill (qFill[s]),
      .inFill  (qFill[SIDES-1-s]),
      .inHead  (qHead[SIDES-1-s]),
      .rdData  (sRdData[s]),
      .irq     (sIrq[s]),
      .strobe  (sStrobe[s])
    );
  end
endmodule

// File: tb/dual_mailbox_bench.sv
`timescale 1ns/1ps
module dual_mailbox_bench;
  logic clk = 0;
  logic rstN = 0;
  always #4 clk = ~clk;

  logic        wrEn [2];
  logic        rdEn [2];
  logic [5:0]  addr [2];
  logic [31:0] wd   [2];
  logic [31:0] rdBus [2];
  logic        irqBus [2];

  int checks = 0;
  int fails  = 0;

  dual_mailbox u_dual_mailbox (
    .clk(clk), .rstN(rstN),
    .aWrEn(wrEn[0]), .aRdEn(rdEn[0]), .aAddr(addr[0]), .aWrData(wd[0]),
    .aRdData(rdBus[0]), .aIrq(irqBus[0]),
    .bWrEn(wrEn[1]), .bRdEn(rdEn[1]), .bAddr(addr[1]), .bWrData(wd[1]),
    .bRdData(rdBus[1]), .bIrq(irqBus[1])
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int s, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn[s] = 1'b1; addr[s] = a; wd[s] = d;
    @(posedge clk); #1;
    wrEn[s] = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic rd(input int s, input logic [5:0] a, output logic [31:0] q);
    @(negedge clk);
    rdEn[s] = 1'b1; addr[s] = a;
    #1 q = rdBus[s];
    @(posedge clk); #1;
    rdEn[s] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] q;
    for (int s = 0; s < 2; s++) begin
      rd(s, 6'h10, q); check("R5 reset status", q, 32'h1);
      rd(s, 6'h14, q); check("R6 reset error", q, 32'h0);
      check("R9 reset irq", {31'b0, irqBus[s]}, 32'h0);
    end
  endtask

  task automatic t_reserved();
    logic [31:0] q;
    wr(0, 6'h04, 32'hDEAD);
    wr(0, 6'h2C, 32'hBEEF);
    wr(0, 6'h19, 32'h7);          // misaligned, must not reach send threshold
    rd(0, 6'h04, q); check("R1 reserved 0x04", q, 32'h0);
    rd(0, 6'h3C, q); check("R1 reserved 0x3C", q, 32'h0);
    rd(0, 6'h18, q); check("R1 misaligned write ignored", q, 32'h0);
    rd(0, 6'h00, q); check("R7 send-data reads zero", q, 32'h0);
    rd(1, 6'h10, q); check("R1 reserved write did not enqueue", q, 32'h1);
  endtask

  task automatic t_transfer();
    logic [31:0] q;
    wr(0, 6'h00, 32'h11111111);
    wr(0, 6'h00, 32'h22222222);
    wr(1, 6'h00, 32'hBBBB0001);
    wr(0, 6'h00, 32'h33333333);
    rd(1, 6'h08, q); check("R2 word1", q, 32'h11111111);
    rd(0, 6'h08, q); check("R2 reverse word", q, 32'hBBBB0001);
    rd(1, 6'h08, q); check("R2 word2", q, 32'h22222222);
    rd(1, 6'h08, q); check("R2 word3", q, 32'h33333333);
    rd(1, 6'h10, q); check("R2 B drained", q & 32'h1, 32'h1);
    rd(0, 6'h10, q); check("R2 A drained", q & 32'h1, 32'h1);
  endtask

  task automatic t_empty();
    logic [31:0] q;
    rd(1, 6'h08, q); check("R4 empty read data", q, 32'h0);
    rd(1, 6'h14, q); check("R4 empty error bit0", q, 32'h1);
    rd(1, 6'h14, q); check("R6 error cleared", q, 32'h0);
    wr(0, 6'h00, 32'hCAFE0001);
    rd(1, 6'h08, q); check("R4 no dequeue on empty", q, 32'hCAFE0001);
  endtask

  task automatic t_full();
    logic [31:0] q;
    for (int i = 0; i < 16; i++) wr(0, 6'h00, 32'hF0000000 + i);
    rd(0, 6'h10, q); check("R10 A status full", q, 32'h3);
    rd(1, 6'h10, q); check("R5 B status above thr", q, 32'h8);
    rd(0, 6'h14, q); check("R10 no error at capacity", q, 32'h0);
    wr(0, 6'h00, 32'h0BAD0BAD);
    rd(0, 6'h14, q); check("R3 full error bit1", q, 32'h2);
    for (int i = 0; i < 16; i++) begin
      rd(1, 6'h08, q); check("R10 delivered word", q, 32'hF0000000 + i);
    end
    rd(1, 6'h10, q); check("R3 dropped word absent", q & 32'h1, 32'h1);
  endtask

  task automatic t_regs();
    logic [31:0] q;
    wr(1, 6'h18, 32'hF);   rd(1, 6'h18, q); check("R7 send thr", q, 32'hF);
    wr(1, 6'h1C, 32'h3A);  rd(1, 6'h1C, q); check("R7 recv thr width", q, 32'hA);
    wr(1, 6'h24, 32'h0);   wr(1, 6'h28, 32'h3);
    rd(1, 6'h28, q); check("R7 pending write ignored", q, 32'h0);
    wr(1, 6'h24, 32'h7);   rd(1, 6'h24, q); check("R7 enable", q, 32'h3);
    wr(1, 6'h24, 32'h0);
    wr(1, 6'h18, 32'h0);   wr(1, 6'h1C, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] q;
    wr(0, 6'h18, 32'h0);
    wr(0, 6'h1C, 32'h1);
    wr(0, 6'h20, 32'h3);
    rd(0, 6'h20, q); check("R8 cleared by ones", q, 32'h0);
    wr(0, 6'h24, 32'h2);
    wr(1, 6'h00, 32'hA1);
    rd(0, 6'h20, q); check("R8 not above thr", q, 32'h0);
    wr(1, 6'h00, 32'hA2);
    rd(0, 6'h20, q); check("R8 recv edge", q, 32'h2);
    rd(0, 6'h28, q); check("R9 pending", q, 32'h2);
    check("R9 irq high", {31'b0, irqBus[0]}, 32'h1);
    wr(0, 6'h20, 32'h2);
    rd(0, 6'h20, q); check("R8 no reset while cond holds", q, 32'h0);
    check("R9 irq low after clear", {31'b0, irqBus[0]}, 32'h0);
    wr(0, 6'h18, 32'h2);
    rd(0, 6'h20, q); check("R8 send edge", q, 32'h1);
    check("R9 irq masked", {31'b0, irqBus[0]}, 32'h0);
    wr(0, 6'h24, 32'h3);
    rd(0, 6'h28, q); check("R9 pending send", q, 32'h1);
    check("R9 irq send", {31'b0, irqBus[0]}, 32'h1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      wrEn[s] = 0; rdEn[s] = 0; addr[s] = '0; wd[s] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_reserved();
    t_transfer();
    t_empty();
    t_full();
    t_regs();
    t_irq();
    finish_run();
  end
endmodule